// File: doc/BRIEF.md
# Reset Cause Flag Register

This block is a single 32-bit status and control register. It keeps a record of which reset sources have fired since software last cleared the record. Six sticky flags are kept for these sources: low-power, window watchdog, independent watchdog, software, power-on and pin. Each flag is set by a one-cycle event input. The flags are not cleared one at a time. A single remove bit clears all of them in one write.

The flags are in the power-reset domain, so they survive a system reset. That lets boot code read why the chip restarted. The rest of the register follows the system reset: the internal low-speed oscillator enable and the access sequencer. The oscillator's ready flag is a read-only view of an input.

Bus access uses a simple select / write / byte-enable port with a `ready` response. A small access sequencer adds one wait state to an access that directly follows a completed one. The states of the sequencer are:

- ST_FREE: the previous cycle completed no access. An access completes at once and the sequencer goes to ST_FOLLOW.
- ST_FOLLOW: the previous cycle completed an access. A new access is held with `ready` low and the sequencer goes to ST_STALL. With no access it returns to ST_FREE.
- ST_STALL: one wait state has been inserted. A held access now completes and the sequencer goes to ST_FOLLOW. With no access it returns to ST_FREE.

Top module: `rst_cause_reg`

## Requirements
- R1: After a power reset (`por_n` low), `rdata` reads 0x0C00_0000 with `osc_rdy` low, and `osc_en` is 0. Flag bits 27 (power-on) and 26 (pin) are set and every other bit is clear.
- R2: A high level on `rst_evt[k]` in one cycle sets flag bit 26+k at the next clock edge. The mapping is: k=5 low-power (bit 31), k=4 window watchdog (30), k=3 independent watchdog (29), k=2 software (28), k=1 power-on (27), k=0 pin (26).
- R3: Once set, a flag stays set across any number of cycles until it is cleared through the remove bit or by a power reset.
- R4: A completed write with `be[3]`=1 and `wdata[24]`=1 clears all six flags at that clock edge. Bit 24 always reads as 0.
- R5: If a reset event arrives in the same cycle as a remove write, the flag for that event is set after the edge, and the other flags are cleared.
- R6: While `sys_rst_n` is low, `osc_en` is 0 and the sequencer is in ST_FREE with `ready` low. The flags keep their values and still record events.
- R7: Bit 0 (`osc_en`) is read/write through byte lane 0 (`be[0]`). A write without `be[0]` leaves it unchanged.
- R8: Bit 1 reads the current level of `osc_rdy`. Writes to bit 1 have no effect.
- R9: Bits 25 and 23..2 read as 0 and ignore writes. Writing ones to bits 31..26 does not set the flags.
- R10: An access whose select is high in the cycle right after a completed access sees `ready` low for exactly one cycle and completes in the next. An access after at least one idle cycle completes with no wait state.
- R11: A write takes effect only on the edge at which `sel`, `wr` and `ready` are all high. Write data offered while `sel` is low or `ready` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, asynchronous, active low; resets everything |
| sys_rst_n | input | 1 | System reset, asynchronous, active low; spares the flags |
| sel | input | 1 | Access request |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables, bit n covers data bits 8n+7..8n |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Register view |
| ready | output | 1 | Access completes in this cycle |
| rst_evt | input | 6 | One-cycle reset-source events (index mapping in R2) |
| osc_rdy | input | 1 | Internal low-speed oscillator ready |
| osc_en | output | 1 | Internal low-speed oscillator enable |

## Verification
The hardest case to reach is a remove write that lands on the same edge as a reset event. The write must actually complete on that edge, and that depends on the access sequencer being in ST_FREE. The bench therefore idles one cycle and then presents the write and the event together, driving them by hand. A second hard case is event recording while the system reset is held. The bench keeps `sys_rst_n` low, pulses an event, and then compares the flags with their values from before the reset. A behavioural model is compared with `rdata`, `ready` and `osc_en` on every cycle, so any stall pattern of back-to-back accesses is covered.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_FOLLOW = 2'd1,
        ST_STALL  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/rcf_wait_fsm.sv
module rcf_wait_fsm
    import rcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic ready
);
    acc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ready   = 1'b0;
        unique case (state_q)
            ST_FREE: begin
                ready   = sel;
                state_d = sel ? ST_FOLLOW : ST_FREE;
            end
            ST_FOLLOW: begin
                ready   = 1'b0;
                state_d = sel ? ST_STALL : ST_FREE;
            end
            ST_STALL: begin
                ready   = sel;
                state_d = sel ? ST_FOLLOW : ST_FREE;
            end
            default: begin
                ready   = 1'b0;
                state_d = ST_FREE;
            end
        endcase
        if (!rst_n) ready = 1'b0;
    end
endmodule

// File: rtl/rcf_flag_bank.sv
module rcf_flag_bank #(
    parameter int                   NUM_FLAGS = 6,
    parameter logic [NUM_FLAGS-1:0] RST_VAL   = '0
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic [NUM_FLAGS-1:0] evt,
    input  logic                 clr,
    output logic [NUM_FLAGS-1:0] flags
);
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)      flags[k] <= RST_VAL[k];
            else if (evt[k]) flags[k] <= 1'b1;
            else if (clr)    flags[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/rcf_osc_ctrl.sv
module rcf_osc_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wbit,
    output logic en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en <= 1'b0;
        else if (wr_en) en <= wbit;
    end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
    parameter int                   DATA_W    = 32,
    parameter int                   NUM_FLAGS = 6,
    parameter int                   FLAG_LSB  = 26,
    parameter int                   RMV_BIT   = 24,
    parameter int                   EN_BIT    = 0,
    parameter int                   RDY_BIT   = 1,
    parameter logic [NUM_FLAGS-1:0] FLAG_RST  = 6'b000011
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 sys_rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [DATA_W/8-1:0]  be,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ready,
    input  logic [NUM_FLAGS-1:0] rst_evt,
    input  logic                 osc_rdy,
    output logic                 osc_en
);
    localparam int RMV_LANE = RMV_BIT / 8;
    localparam int EN_LANE  = EN_BIT / 8;

    logic                 sys_domain_n;
    logic                 wr_fire;
    logic                 rmv_fire;
    logic [NUM_FLAGS-1:0] flags;

    assign sys_domain_n = por_n & sys_rst_n;

    rcf_wait_fsm u_fsm (
        .clk   (clk),
        .rst_n (sys_domain_n),
        .sel   (sel),
        .ready (ready)
    );

    assign wr_fire  = sel & wr & ready;
    assign rmv_fire = wr_fire & be[RMV_LANE] & wdata[RMV_BIT];

    rcf_flag_bank #(
        .NUM_FLAGS (NUM_FLAGS),
        .RST_VAL   (FLAG_RST)
    ) u_flags (
        .clk   (clk),
        .por_n (por_n),
        .evt   (rst_evt),
        .clr   (rmv_fire),
        .flags (flags)
    );

    rcf_osc_ctrl u_osc (
        .clk   (clk),
        .rst_n (sys_domain_n),
        .wr_en (wr_fire & be[EN_LANE]),
        .wbit  (wdata[EN_BIT]),
        .en    (osc_en)
    );

    always_comb begin
        rdata                          = '0;
        rdata[FLAG_LSB +: NUM_FLAGS]   = flags;
        rdata[RDY_BIT]                 = osc_rdy;
        rdata[EN_BIT]                  = osc_en;
    end
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk (
    input logic        clk,
    input logic        por_n,
    input logic        sys_rst_n,
    input logic        sel,
    input logic        wr,
    input logic [3:0]  be,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic        ready,
    input logic [5:0]  rst_evt,
    input logic        osc_en
);
    logic clr_now;
    assign clr_now = sel && wr && ready && be[3] && wdata[24];

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_evt != 6'b0) |=> ((rdata[31:26] & $past(rst_evt)) == $past(rst_evt)));

    // R3
    flags_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_now && rst_evt == 6'b0) |=> $stable(rdata[31:26]));

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rdata[25:2] == 24'b0));

    // R10
    follow_stall_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (sel && ready) |=> !ready);

    // R6
    osc_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |-> (!osc_en && !ready));
endmodule

bind rst_cause_reg rst_cause_reg_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .sel       (sel),
    .wr        (wr),
    .be        (be),
    .wdata     (wdata),
    .rdata     (rdata),
    .ready     (ready),
    .rst_evt   (rst_evt),
    .osc_en    (osc_en)
);

// File: tb/tb_rst_cause_reg.sv
module tb_rst_cause_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  be = 4'b0;
    logic [31:0] wdata = 32'b0;
    logic [31:0] rdata;
    logic        ready;
    logic [5:0]  rst_evt = 6'b0;
    logic        osc_rdy = 1'b0;
    logic        osc_en;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    string cur_req = "R1";

    rst_cause_reg dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .sel(sel), .wr(wr),
        .be(be), .wdata(wdata), .rdata(rdata), .ready(ready),
        .rst_evt(rst_evt), .osc_rdy(osc_rdy), .osc_en(osc_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    logic [5:0] m_flags = 6'b000011;
    logic       m_en    = 1'b0;
    logic       m_prev  = 1'b0;

    function automatic logic exp_ready();
        return sel && sys_rst_n && por_n && !m_prev;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) m_flags <= 6'b000011;
        else begin
            if (sel && wr && exp_ready() && be[3] && wdata[24])
                m_flags <= rst_evt;
            else
                m_flags <= m_flags | rst_evt;
        end
    end

    always @(posedge clk or negedge por_n or negedge sys_rst_n) begin
        if (!por_n || !sys_rst_n) begin
            m_en   <= 1'b0;
            m_prev <= 1'b0;
        end else begin
            if (sel && wr && exp_ready() && be[0]) m_en <= wdata[0];
            m_prev <= sel && exp_ready();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check(cur_req, rdata, {m_flags, 24'b0, osc_rdy, m_en});
        check(cur_req, {31'b0, ready}, {31'b0, exp_ready()});
        check(cur_req, {31'b0, osc_en}, {31'b0, m_en});
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic access(input logic w, input logic [3:0] b, input logic [31:0] d,
                          output int waits);
        waits = 0;
        sel = 1'b1; wr = w; be = b; wdata = d;
        forever begin
            @(negedge clk);
            if (ready) break;
            waits++;
        end
        @(posedge clk); #1;
        sel = 1'b0; wr = 1'b0; be = 4'b0; wdata = 32'b0;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        rst_evt = e;
        step(1);
        rst_evt = 6'b0;
    endtask

    initial begin
        int w1, w2;
        // R1 power reset
        cur_req = "R1";
        step(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        step(1);
        @(negedge clk);
        check("R1", rdata, 32'h0C00_0000);
        check("R1", {31'b0, osc_en}, 32'b0);
        step(1);

        // R4 remove
        cur_req = "R4";
        access(1'b1, 4'b1000, 32'h0100_0000, w1);
        @(negedge clk);
        check("R4", rdata, 32'h0);
        step(1);

        // R2 mapping per bit
        cur_req = "R2";
        for (int k = 0; k < 6; k++) begin
            pulse_evt(6'b1 << k);
            @(negedge clk);
            check("R2", rdata & 32'hFC00_0000, 32'h0400_0000 << k);
            step(1);
            access(1'b1, 4'b1000, 32'h0100_0000, w1);
            step(1);
        end
        pulse_evt(6'b100000);
        @(negedge clk);
        check("R2", rdata, 32'h8000_0000);

        // R3 sticky
        cur_req = "R3";
        step(20);
        @(negedge clk);
        check("R3", rdata, 32'h8000_0000);
        step(1);

        // R9 flag bits and reserved bits not writable
        cur_req = "R9";
        access(1'b1, 4'b1000, 32'hFE00_0000, w1);
        step(1);
        access(1'b1, 4'b1111, 32'h02FF_FFFC, w1);
        @(negedge clk);
        check("R9", rdata, 32'h8000_0000);
        step(1);

        // R7 enable lane
        cur_req = "R7";
        access(1'b1, 4'b1110, 32'h0000_0001, w1);
        @(negedge clk);
        check("R7", {31'b0, osc_en}, 32'b0);
        step(1);
        access(1'b1, 4'b0001, 32'h0000_0001, w1);
        @(negedge clk);
        check("R7", {31'b0, osc_en}, 32'b1);
        step(1);

        // R8 ready bit
        cur_req = "R8";
        osc_rdy = 1'b1;
        @(negedge clk);
        check("R8", rdata & 32'h2, 32'h2);
        step(1);
        osc_rdy = 1'b0;
        access(1'b1, 4'b0001, 32'h0000_0003, w1);
        @(negedge clk);
        check("R8", rdata & 32'h3, 32'h1);
        step(1);

        // R11 write with sel low does nothing
        cur_req = "R11";
        wr = 1'b1; be = 4'b1111; wdata = 32'h0100_0000;
        step(2);
        wr = 1'b0; be = 4'b0; wdata = 32'b0;
        @(negedge clk);
        check("R11", rdata, 32'h8000_0001);
        step(1);

        // R10 back-to-back waits
        cur_req = "R10";
        access(1'b0, 4'b1111, 32'b0, w1);
        access(1'b0, 4'b1111, 32'b0, w2);
        check("R10", w1, 0);
        check("R10", w2, 1);
        step(1);
        access(1'b0, 4'b1111, 32'b0, w1);
        check("R10", w1, 0);
        step(1);
        // R11 write held through a stall lands once
        access(1'b0, 4'b1111, 32'b0, w1);
        access(1'b1, 4'b0001, 32'h0, w2);
        @(negedge clk);
        check("R11", {31'b0, osc_en}, 32'b0);
        check("R11", w2, 1);
        step(1);

        // R5 event vs remove in same cycle
        cur_req = "R5";
        pulse_evt(6'b001000);
        step(1);
        sel = 1'b1; wr = 1'b1; be = 4'b1000; wdata = 32'h0100_0000;
        rst_evt = 6'b000100;
        step(1);
        sel = 1'b0; wr = 1'b0; be = 4'b0; wdata = 32'b0; rst_evt = 6'b0;
        @(negedge clk);
        check("R5", rdata & 32'hFC00_0000, 32'h1000_0000);
        step(1);

        // R6 system reset spares flags
        cur_req = "R6";
        access(1'b1, 4'b0001, 32'h1, w1);
        step(1);
        sys_rst_n = 1'b0;
        step(1);
        pulse_evt(6'b010000);
        sel = 1'b1;
        @(negedge clk);
        check("R6", {31'b0, ready}, 32'b0);
        check("R6", {31'b0, osc_en}, 32'b0);
        check("R6", rdata & 32'hFC00_0000, 32'h5000_0000);
        step(1);
        sel = 1'b0;
        sys_rst_n = 1'b1;
        step(2);
        @(negedge clk);
        check("R6", rdata, 32'h5000_0000);

        // R1 power reset again restores flags
        cur_req = "R1";
        step(1);
        por_n = 1'b0;
        step(2);
        por_n = 1'b1;
        step(1);
        @(negedge clk);
        check("R1", rdata, 32'h0C00_0000);
        step(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule